// File: doc/BRIEF.md
# Gated J-K Storage Bit with Asynchronous Force

A single storage bit that follows J-K rules on each rising clock edge. The J term and the K term are each formed by ANDing a small group of gate inputs, so the bit can be qualified by several enables without outside logic. A build parameter selects the polarity of the gate inputs. In the uniform build every gate input is active high. In the mixed build the last input of each group is active low, which lets a single data wire drive J and K in opposite senses.

Two asynchronous active-high inputs override the clocked path at any time. One forces the bit to one and the other forces it to zero. The true and complement outputs are driven independently, so when both force inputs are high together both outputs read high. That case is defined behaviour and not an illegal one. Typical uses are clock division with every gate input tied high and a D-type register built from the mixed build.

Top module: `gated_jk_bit`

## Requirements
- R1: With MIXED_POL=0 the effective J is the AND of all bits of `j_in`, and the effective K is the AND of all bits of `k_in`.
- R2: With MIXED_POL=1 the most significant bit of `j_in` and of `k_in` (index GATES-1) counts inverted in its AND. All other bits count true.
- R3: With both force inputs low, a rising edge with J=0, K=0 leaves `q` unchanged.
- R4: With both force inputs low, a rising edge with J=0, K=1 makes `q`=0 and `q_n`=1.
- R5: With both force inputs low, a rising edge with J=1, K=0 makes `q`=1 and `q_n`=0.
- R6: With both force inputs low, a rising edge with J=1, K=1 inverts `q`.
- R7: With both force inputs low, `q_n` is always the inverse of `q`, and neither output changes except at a rising clock edge.
- R8: `set_a` high with `clr_a` low gives `q`=1 and `q_n`=0 without waiting for a clock edge. J and K are ignored while it is held.
- R9: `clr_a` high with `set_a` low gives `q`=0 and `q_n`=1 without waiting for a clock edge. J and K are ignored while it is held.
- R10: `set_a` and `clr_a` high together give `q`=1 and `q_n`=1.
- R11: After the force inputs drop, the bit keeps the value last forced until the next rising edge. That value is 1 when `set_a` was involved (alone or with `clr_a`) and 0 when `clr_a` alone was involved. A clock edge during a force re-applies the current force.
- R12: With MIXED_POL=0 and every gate input high, `q` inverts on every rising edge, halving the clock rate.
- R13: With MIXED_POL=1, a data bit d on `j_in[0]` and `k_in[GATES-1]`, with all other gate inputs high except `j_in[GATES-1]` low, makes `q` equal d after each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| set_a | input | 1 | Asynchronous force to one, active high |
| clr_a | input | 1 | Asynchronous force to zero, active high |
| j_in | input | GATES | J gate inputs, ANDed |
| k_in | input | GATES | K gate inputs, ANDed |
| q | output | 1 | Stored bit |
| q_n | output | 1 | Complement of stored bit, high for both forces |

## Verification
The clocked J-K update and the asynchronous force can both fall in the same cycle, and a force can also rise and drop between two edges. The bench changes the force inputs mid-cycle, sometimes both together and sometimes dropping one while the other stays high. It then compares the outputs right after each change and again after the following rising edge. A bench reference model derived from the requirements judges both builds, the uniform one and the mixed one, driven from the same stimulus.

// File: rtl/gated_jk_pkg.sv
package gated_jk_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_ZERO   = 2'd1,
        ACT_ONE    = 2'd2,
        ACT_INVERT = 2'd3
    } jk_action_e;

    typedef struct packed {
        logic bit_val;
    } jk_store_t;

endpackage

// File: rtl/jk_gate_and.sv
module jk_gate_and #(
    parameter int GATES    = 3,
    parameter bit INV_LAST = 1'b0
) (
    input  logic [GATES-1:0] gate_in,
    output logic             term_out
);
    localparam int LAST = GATES - 1;

    logic [GATES-1:0] polar;

    generate
        for (genvar gi = 0; gi < GATES; gi++) begin : g_pol
            if (INV_LAST && gi == LAST) begin : g_inv
                assign polar[gi] = ~gate_in[gi];
            end else begin : g_true
                assign polar[gi] = gate_in[gi];
            end
        end
    endgenerate

    assign term_out = &polar;

endmodule

// File: rtl/jk_next_state.sv
module jk_next_state
    import gated_jk_pkg::*;
(
    input  jk_store_t  cur_q,
    input  logic       j_term,
    input  logic       k_term,
    output jk_action_e act,
    output jk_store_t  nxt_d
);
    always_comb begin
        act   = jk_action_e'({j_term, k_term});
        nxt_d = cur_q;
        unique case (act)
            ACT_KEEP:   nxt_d.bit_val = cur_q.bit_val;
            ACT_ZERO:   nxt_d.bit_val = 1'b0;
            ACT_ONE:    nxt_d.bit_val = 1'b1;
            ACT_INVERT: nxt_d.bit_val = ~cur_q.bit_val;
            default:    nxt_d.bit_val = cur_q.bit_val;
        endcase
    end

endmodule

// File: rtl/gated_jk_bit.sv
module gated_jk_bit
    import gated_jk_pkg::*;
#(
    parameter int GATES     = 3,
    parameter bit MIXED_POL = 1'b0
) (
    input  logic             clk,
    input  logic             set_a,
    input  logic             clr_a,
    input  logic [GATES-1:0] j_in,
    input  logic [GATES-1:0] k_in,
    output logic             q,
    output logic             q_n
);
    logic       j_term;
    logic       k_term;
    jk_action_e act;
    jk_store_t  store_q;
    jk_store_t  store_d;

    jk_gate_and #(.GATES(GATES), .INV_LAST(MIXED_POL)) u_jgate (
        .gate_in  (j_in),
        .term_out (j_term)
    );

    jk_gate_and #(.GATES(GATES), .INV_LAST(MIXED_POL)) u_kgate (
        .gate_in  (k_in),
        .term_out (k_term)
    );

    jk_next_state u_next (
        .cur_q  (store_q),
        .j_term (j_term),
        .k_term (k_term),
        .act    (act),
        .nxt_d  (store_d)
    );

    // Force inputs win over the clock; set has priority for the kept value.
    always_ff @(posedge clk or posedge set_a or posedge clr_a) begin
        if (set_a) begin
            store_q.bit_val <= 1'b1;
        end else if (clr_a) begin
            store_q.bit_val <= 1'b0;
        end else begin
            store_q <= store_d;
        end
    end

    always_comb begin
        q   = set_a | (~clr_a & store_q.bit_val);
        q_n = clr_a | (~set_a & ~store_q.bit_val);
    end

    // R10
    both_force_high_chk: assert property (@(posedge clk)
        (set_a && clr_a) |-> (q && q_n));

    // R8
    set_force_chk: assert property (@(posedge clk)
        (set_a && !clr_a) |-> (q && !q_n));

    // R9
    clr_force_chk: assert property (@(posedge clk)
        (clr_a && !set_a) |-> (!q && q_n));

    // R7
    complement_chk: assert property (@(posedge clk)
        (!set_a && !clr_a) |-> (q != q_n));

    // R6
    invert_act_chk: assert property (@(posedge clk)
        (!set_a && !clr_a && j_term && k_term) |-> (act == ACT_INVERT));

endmodule

// File: tb/gated_jk_bit_tb_top.sv
module gated_jk_bit_tb_top;
    localparam int  GATES   = 3;
    localparam time CLK_PER = 10;

    logic             clk   = 1'b0;
    logic             set_b = 1'b0;
    logic             clr_b = 1'b0;
    logic [GATES-1:0] jb    = '0;
    logic [GATES-1:0] kb    = '0;
    logic             q0, qn0, q1, qn1;
    logic             ref0, ref1;
    int               n_chk  = 0;
    int               n_fail = 0;
    bit               done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    gated_jk_bit #(.GATES(GATES), .MIXED_POL(1'b0)) dut_i (
        .clk(clk), .set_a(set_b), .clr_a(clr_b), .j_in(jb), .k_in(kb), .q(q0), .q_n(qn0));

    gated_jk_bit #(.GATES(GATES), .MIXED_POL(1'b1)) dut_mix_i (
        .clk(clk), .set_a(set_b), .clr_a(clr_b), .j_in(jb), .k_in(kb), .q(q1), .q_n(qn1));

    // R1 / R2 effective gate term from the requirement text
    function automatic logic term_of(logic [GATES-1:0] g, bit mixed);
        logic t = 1'b1;
        for (int i = 0; i < GATES; i++)
            t = t & ((mixed && i == GATES-1) ? ~g[i] : g[i]);
        return t;
    endfunction

    function automatic logic jk_rule(logic st, logic j, logic k);
        if (!j && !k) return st;
        if (!j && k)  return 1'b0;
        if (j && !k)  return 1'b1;
        return ~st;
    endfunction

    function automatic string tag_of(logic j, logic k);
        if (set_b && clr_b) return "R10";
        if (set_b) return "R8";
        if (clr_b) return "R9";
        if (!j && !k) return "R3";
        if (!j && k)  return "R4";
        if (j && !k)  return "R5";
        return "R6";
    endfunction

    always @(posedge clk or posedge set_b or posedge clr_b) begin
        if (set_b) begin
            ref0 <= 1'b1; ref1 <= 1'b1;
        end else if (clr_b) begin
            ref0 <= 1'b0; ref1 <= 1'b0;
        end else begin
            ref0 <= jk_rule(ref0, term_of(jb, 1'b0), term_of(kb, 1'b0));
            ref1 <= jk_rule(ref1, term_of(jb, 1'b1), term_of(kb, 1'b1));
        end
    end

    task automatic chk(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cmp_all(string tag);
        chk(tag, q0,  set_b | (~clr_b & ref0));
        chk(tag, qn0, clr_b | (~set_b & ~ref0));
        chk(tag, q1,  set_b | (~clr_b & ref1));
        chk(tag, qn1, clr_b | (~set_b & ~ref1));
    endtask

    task automatic step(logic s, logic r, logic [GATES-1:0] j, logic [GATES-1:0] k);
        @(negedge clk);
        #1;
        cmp_all("R7");
        set_b = s; clr_b = r; jb = j; kb = k;
        #1;
        cmp_all(tag_of(term_of(j, 1'b0), term_of(k, 1'b0)));
    endtask

    initial begin
        #2 clr_b = 1'b1;
        #1;
        // R9 reset state through the clear force
        chk("R9", q0, 1'b0); chk("R9", qn0, 1'b1);
        chk("R9", q1, 1'b0); chk("R9", qn1, 1'b1);

        // R5 / R4 / R3 / R6 directed, uniform build; mixed sees bit 2 inverted (R2)
        step(0, 0, 3'b111, 3'b011);
        step(0, 0, 3'b011, 3'b111);
        step(0, 0, 3'b000, 3'b000);
        step(0, 0, 3'b111, 3'b111);
        step(0, 0, 3'b011, 3'b011);

        // R8 set mid-cycle with J/K asking to clear, then held across an edge
        step(1, 0, 3'b000, 3'b111);
        step(1, 0, 3'b000, 3'b111);
        // R10 both high, then drop set leaving clear alone, then drop clear (R11)
        step(1, 1, 3'b111, 3'b111);
        step(0, 1, 3'b111, 3'b000);
        step(0, 0, 3'b000, 3'b000);
        chk("R11", q0, 1'b0);
        // R11 both then release together: kept value is 1
        @(negedge clk); #1;
        set_b = 1; clr_b = 1; #2;
        set_b = 0; clr_b = 0; #1;
        chk("R11", q0, 1'b1); chk("R11", q1, 1'b1);
        cmp_all("R11");

        // R12 divide by two, uniform build
        begin
            logic prev;
            step(0, 0, 3'b111, 3'b111);
            for (int c = 0; c < 8; c++) begin
                prev = q0;
                @(negedge clk); #1;
                chk("R12", q0, ~prev);
            end
        end

        // R13 D-type from the mixed build
        for (int c = 0; c < 12; c++) begin
            logic d;
            d = 1'(c % 3 == 0) ^ 1'(c[0]);
            step(0, 0, {1'b0, 1'b1, d}, {d, 1'b1, 1'b1});
            @(negedge clk); #1;
            chk("R13", q1, d);
            chk("R13", qn1, ~d);
        end

        // random mix
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 400; c++) begin
            logic [7:0] pick;
            pick = 8'($urandom);
            step(pick < 8'd20, pick > 8'd235,
                 GATES'($urandom | $urandom), GATES'($urandom | $urandom));
        end
        step(0, 0, '0, '0);
        done = 1'b1;
    end

    initial begin
        #(CLK_PER * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
        end
        done = 1'b1;
    end

    initial begin
        wait (done);
        #1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule